// File: doc/BRIEF.md
# Real-Time Clock Time and Calendar Counter

This block holds the wall-clock time and the calendar: seconds, minutes, hours, day of week, day of month, month, year and century. It moves forward by one second for each pulse on a 1 Hz tick input. A host reads and writes the counters through a flat byte-addressed port. Two control bytes select how the counters are encoded. Each time field can be presented as packed BCD or as plain binary. The hour field can use a 24-hour or a 12-hour layout, and the 12-hour layout marks PM in hour bit 7.

The counters are kept inside in one encoding-neutral form: binary, 24-hour. Every host read converts to the presentation selected at that moment, and every host write converts back from it. Changing the format therefore re-encodes the time and leaves it unchanged. A tick does not change the counters at once. It raises an update-in-progress status for a fixed number of clock cycles, then applies the one-second step and pulses an update-ended output. Software uses this warning to keep away from the counters during the transfer. A hold bit and the oscillator divider field can both block updates, so the host can load a consistent time. An optional daylight-saving rule moves the hour on two fixed Sundays of the year.

Top module: `tod_calendar`

## Requirements
- R1: After reset the fields hold 00:00:00 and day of week 1, date 1, month 1, year 0 and century 20. Read in the reset format, these are hour 0x12 and century 0x20. Control A reads 0x20 (divider 010, UIP 0) and control B reads 0x00.
- R2: The fields sit at these byte offsets: seconds 0x00, minutes 0x02, hours 0x04, day of week 0x06, date 0x07, month 0x08, year 0x09, century 0x7F. Control A is at 0x0A and control B at 0x0B. Any other address reads 0x00, and a write to it changes nothing. Bit 7 of control A reads the update-in-progress status, and writes to that bit are ignored.
- R3: Control B bit 2 selects the encoding of every field on reads and writes: 0 for packed BCD, 1 for binary. Switching it re-encodes the stored time and does not alter it.
- R4: Control B bit 1 selects the hour layout. With 1 the hour reads 0–23. With 0 it reads 1–12 with bit 7 set for PM, so midnight reads 0x12 in BCD or 0x0C in binary, and noon reads 0x92 in BCD or 0x8C in binary.
- R5: Updates are enabled when control A bits 6:4 equal 010 and control B bit 7 is 0. With updates enabled and no update pending, a tick raises `uip` in the next cycle. `uip` stays high for exactly UIP_LEAD cycles. In the cycle in which it falls, the fields show the time one second later and `update_done` is high for one cycle.
- R6: A tick is ignored while control B bit 7 is 1, while the divider is not 010, or while an update is already pending. In these cases `uip` does not rise and the time does not change.
- R7: Seconds and minutes wrap from 59 to 0, each carrying into the next field. Hours wrap from 23 to 0 and carry into the day. Day of week runs 1 to 7 and wraps from 7 back to 1 when the day advances.
- R8: The date wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for February when the year is divisible by 4 (28 otherwise). Month 12 wraps to 1 and increments the year.
- R9: Year 99 wraps to 0 and increments the century.
- R10: When control B bit 0 is 1, two daylight-saving steps apply. On a Sunday (day of week 1) in April with date 1–7, the step after 01:59:59 gives 03:00:00. On a Sunday in October with date 25–31, the step after 01:59:59 gives 01:00:00, and this happens once per day. The fall-back is re-armed when the hour passes midnight or when the host writes any time field. When control B bit 0 is 0, neither adjustment applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| host_addr | input | 8 | Register byte address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write enable, captured at the clock edge |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| uip | output | 1 | Update in progress |
| update_done | output | 1 | One-cycle pulse when an update has been applied |

## Verification
The assertions assume that the host writes only legal values in the current format, that it writes time fields only while updates are held or no update is pending, and that each tick is a separate pulse. Under those conditions they require the stored fields to stay within their ranges after every step, and the hour to move by at most one when daylight saving is off. The stimulus loads every random time with the hold bit set. Each field is drawn inside its legal range for the chosen month and year, and the values are biased toward the last second, minute, hour and day so that carries happen often. The bench always waits for `uip` to fall before the next register access.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] dow;
    logic [6:0] dom;
    logic [6:0] mon;
    logic [6:0] year;
    logic [6:0] cent;
  } tod_time_t;

  localparam logic [7:0] ADR_SEC  = 8'h00;
  localparam logic [7:0] ADR_MIN  = 8'h02;
  localparam logic [7:0] ADR_HOUR = 8'h04;
  localparam logic [7:0] ADR_DOW  = 8'h06;
  localparam logic [7:0] ADR_DOM  = 8'h07;
  localparam logic [7:0] ADR_MON  = 8'h08;
  localparam logic [7:0] ADR_YEAR = 8'h09;
  localparam logic [7:0] ADR_CTLA = 8'h0A;
  localparam logic [7:0] ADR_CTLB = 8'h0B;
  localparam logic [7:0] ADR_CENT = 8'h7F;

  localparam logic [2:0] DIV_RUN  = 3'b010;
  localparam logic [6:0] CTLA_RST = 7'h20;

  // binary 0..99 to packed BCD
  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin_mode);
    return bin_mode ? {1'b0, v} : bin_to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin_mode);
    return bin_mode ? b[6:0] : bcd_to_bin(b);
  endfunction

  // internal hour is 0..23; 12-hour view puts PM in bit 7
  function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin_mode,
                                          input logic full_day);
    logic       pm;
    logic [6:0] h12;
    if (full_day) return enc_field(h, bin_mode);
    pm  = (h >= 7'd12);
    h12 = pm ? h - 7'd12 : h;
    if (h12 == 7'd0) h12 = 7'd12;
    return {pm, 7'b0} | enc_field(h12, bin_mode);
  endfunction

  function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin_mode,
                                          input logic full_day);
    logic [6:0] v;
    if (full_day) return dec_field(b, bin_mode);
    v = dec_field({1'b0, b[6:0]}, bin_mode);
    if (v == 7'd12) v = 7'd0;
    if (b[7]) v = v + 7'd12;
    return v;
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] year);
    case (mon)
      7'd2:                          return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:       return 7'd30;
      default:                       return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/tod_step.sv
`timescale 1ns/1ps
module tod_step
  import tod_pkg::*;
(
  input  tod_time_t cur,
  input  logic      dse,
  input  logic      fall_done,
  output tod_time_t nxt,
  output logic      fall_done_nxt
);

  logic [6:0] dim;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;
  logic at_0159, spring_hit, fall_hit;

  assign dim       = month_days(cur.mon, cur.year);
  assign sec_wrap  = cur.sec >= 7'd59;
  assign min_wrap  = sec_wrap && (cur.min >= 7'd59);
  assign at_0159   = min_wrap && (cur.hour == 7'd1) && (cur.dow == 7'd1);
  assign spring_hit = dse && at_0159 && (cur.mon == 7'd4) && (cur.dom <= 7'd7);
  assign fall_hit   = dse && at_0159 && (cur.mon == 7'd10) && (cur.dom >= 7'd25) && !fall_done;
  assign hour_wrap = min_wrap && (cur.hour >= 7'd23);
  assign day_wrap  = hour_wrap && (cur.dom >= dim);
  assign mon_wrap  = day_wrap && (cur.mon >= 7'd12);
  assign year_wrap = mon_wrap && (cur.year >= 7'd99);

  always_comb begin
    nxt           = cur;
    fall_done_nxt = fall_done;
    nxt.sec = sec_wrap ? 7'd0 : cur.sec + 7'd1;
    if (sec_wrap) nxt.min = min_wrap ? 7'd0 : cur.min + 7'd1;
    if (spring_hit) begin
      nxt.hour = 7'd3;
    end else if (fall_hit) begin
      nxt.hour      = 7'd1;
      fall_done_nxt = 1'b1;
    end else if (min_wrap) begin
      nxt.hour = hour_wrap ? 7'd0 : cur.hour + 7'd1;
    end
    if (hour_wrap) begin
      fall_done_nxt = 1'b0;
      nxt.dow = (cur.dow >= 7'd7) ? 7'd1 : cur.dow + 7'd1;
      nxt.dom = day_wrap ? 7'd1 : cur.dom + 7'd1;
    end
    if (day_wrap)  nxt.mon  = mon_wrap ? 7'd1 : cur.mon + 7'd1;
    if (mon_wrap)  nxt.year = year_wrap ? 7'd0 : cur.year + 7'd1;
    if (year_wrap) nxt.cent = (cur.cent >= 7'd99) ? 7'd0 : cur.cent + 7'd1;
  end

endmodule

// File: rtl/tod_seq.sv
`timescale 1ns/1ps
module tod_seq #(
  parameter int UIP_LEAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_ok,
  output logic uip,
  output logic fire,
  output logic done
);

  localparam int CW = (UIP_LEAD > 1) ? $clog2(UIP_LEAD) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          start, last;

  assign start = tick && !busy_q && run_ok;
  assign last  = busy_q && (cnt_q == CW'(UIP_LEAD - 1));
  assign fire  = last && run_ok;
  assign uip   = busy_q;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_start_raises_uip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> uip);
  p_fire_under_uip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> uip);
  p_done_at_uip_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (done && !uip));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_blocked_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && !run_ok) |=> !uip);

endmodule

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_we,
  input  logic       uip,
  input  logic       upd_fire,
  input  tod_time_t  nxt_time,
  input  logic       nxt_fall_done,
  output tod_time_t  time_q,
  output logic       fall_done_q,
  output logic       hold_set,
  output logic       dse_on,
  output logic [2:0] divider,
  output logic [7:0] host_rdata
);

  logic [6:0] ctla_q;
  logic [7:0] ctlb_q;
  logic       bin_mode, full_day;
  logic [6:0] w_field, w_hour;
  logic       addr_known;

  assign bin_mode = ctlb_q[2];
  assign full_day = ctlb_q[1];
  assign hold_set = ctlb_q[7];
  assign dse_on   = ctlb_q[0];
  assign divider  = ctla_q[6:4];
  assign w_field  = dec_field(host_wdata, bin_mode);
  assign w_hour   = dec_hour(host_wdata, bin_mode, full_day);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q      <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, dow: 7'd1, dom: 7'd1,
                       mon: 7'd1, year: 7'd0, cent: 7'd20};
      fall_done_q <= 1'b0;
      ctla_q      <= CTLA_RST;
      ctlb_q      <= 8'h00;
    end else begin
      if (upd_fire) begin
        time_q      <= nxt_time;
        fall_done_q <= nxt_fall_done;
      end
      if (host_we) begin
        case (host_addr)
          ADR_SEC:  begin time_q.sec  <= w_field; fall_done_q <= 1'b0; end
          ADR_MIN:  begin time_q.min  <= w_field; fall_done_q <= 1'b0; end
          ADR_HOUR: begin time_q.hour <= w_hour;  fall_done_q <= 1'b0; end
          ADR_DOW:  begin time_q.dow  <= w_field; fall_done_q <= 1'b0; end
          ADR_DOM:  begin time_q.dom  <= w_field; fall_done_q <= 1'b0; end
          ADR_MON:  begin time_q.mon  <= w_field; fall_done_q <= 1'b0; end
          ADR_YEAR: begin time_q.year <= w_field; fall_done_q <= 1'b0; end
          ADR_CENT: begin time_q.cent <= w_field; fall_done_q <= 1'b0; end
          ADR_CTLA: ctla_q <= host_wdata[6:0];
          ADR_CTLB: ctlb_q <= host_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    addr_known = 1'b1;
    host_rdata = 8'h00;
    case (host_addr)
      ADR_SEC:  host_rdata = enc_field(time_q.sec, bin_mode);
      ADR_MIN:  host_rdata = enc_field(time_q.min, bin_mode);
      ADR_HOUR: host_rdata = enc_hour(time_q.hour, bin_mode, full_day);
      ADR_DOW:  host_rdata = enc_field(time_q.dow, bin_mode);
      ADR_DOM:  host_rdata = enc_field(time_q.dom, bin_mode);
      ADR_MON:  host_rdata = enc_field(time_q.mon, bin_mode);
      ADR_YEAR: host_rdata = enc_field(time_q.year, bin_mode);
      ADR_CENT: host_rdata = enc_field(time_q.cent, bin_mode);
      ADR_CTLA: host_rdata = {uip, ctla_q};
      ADR_CTLB: host_rdata = ctlb_q;
      default:  addr_known = 1'b0;
    endcase
  end

  p_time_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !upd_fire) |=> $stable(time_q));
  p_hold_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_set && !host_we) |=> $stable(time_q));
  p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !addr_known && !upd_fire) |=> ($stable(time_q) && $stable(ctlb_q) && $stable(ctla_q)));
  p_step_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !host_we && time_q.sec < 7'd60 && time_q.min < 7'd60 && time_q.hour < 7'd24)
    |=> (time_q.sec < 7'd60 && time_q.min < 7'd60 && time_q.hour < 7'd24));
  p_hour_moves_by_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !host_we && !dse_on && time_q.hour < 7'd24)
    |=> (time_q.hour == 7'd0 || time_q.hour == $past(time_q.hour) ||
         time_q.hour == $past(time_q.hour) + 7'd1));

endmodule

// File: rtl/tod_calendar.sv
`timescale 1ns/1ps
module tod_calendar
  import tod_pkg::*;
#(
  parameter int UIP_LEAD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_we,
  output logic [7:0] host_rdata,
  output logic       uip,
  output logic       update_done
);

  tod_time_t  time_q, nxt_time;
  logic       fall_done_q, nxt_fall_done;
  logic       hold_set, dse_on, run_ok, upd_fire;
  logic [2:0] divider;

  assign run_ok = (divider == DIV_RUN) && !hold_set;

  tod_seq #(.UIP_LEAD(UIP_LEAD)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1hz),
    .run_ok (run_ok),
    .uip    (uip),
    .fire   (upd_fire),
    .done   (update_done)
  );

  tod_step u_step (
    .cur           (time_q),
    .dse           (dse_on),
    .fall_done     (fall_done_q),
    .nxt           (nxt_time),
    .fall_done_nxt (nxt_fall_done)
  );

  tod_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_we       (host_we),
    .uip           (uip),
    .upd_fire      (upd_fire),
    .nxt_time      (nxt_time),
    .nxt_fall_done (nxt_fall_done),
    .time_q        (time_q),
    .fall_done_q   (fall_done_q),
    .hold_set      (hold_set),
    .dse_on        (dse_on),
    .divider       (divider),
    .host_rdata    (host_rdata)
  );

endmodule

// File: tb/sim_tod_calendar.sv
`timescale 1ns/1ps
module sim_tod_calendar;
  localparam int LEAD = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  wire  [7:0] rdata;
  wire        uip, done;

  always #10 clk = ~clk;

  tod_calendar #(.UIP_LEAD(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .host_addr(addr),
    .host_wdata(wdata), .host_we(we), .host_rdata(rdata),
    .uip(uip), .update_done(done)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int ms, mm, mh, mw, md, mo, my, mc;
  bit mfd, mdm, mh24, mdse;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int dim(int o, int y);
    if (o == 2) return (y % 4 == 0) ? 29 : 28;
    if (o == 4 || o == 6 || o == 9 || o == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int v);
    return mdm ? v : (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int enc_hr(int h);
    int x;
    if (mh24) return enc(h);
    x = h % 12;
    if (x == 0) x = 12;
    return enc(x) + ((h >= 12) ? 128 : 0);
  endfunction

  task automatic model_tick();
    if (ms < 59) ms++;
    else begin
      ms = 0;
      if (mm < 59) mm++;
      else begin
        mm = 0;
        if (mdse && mh == 1 && mw == 1 && mo == 4 && md <= 7) mh = 3;
        else if (mdse && mh == 1 && mw == 1 && mo == 10 && md >= 25 && !mfd) begin
          mh = 1; mfd = 1;
        end else if (mh < 23) mh++;
        else begin
          mh = 0; mfd = 0;
          mw = (mw % 7) + 1;
          if (md < dim(mo, my)) md++;
          else begin
            md = 1;
            if (mo < 12) mo++;
            else begin
              mo = 1;
              if (my < 99) my++;
              else begin my = 0; mc = (mc + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rdata);
  endtask

  task automatic wr_mode(bit set, bit dm, bit h24, bit dse);
    mdm = dm; mh24 = h24; mdse = dse;
    wr(8'h0B, {set, 4'b0000, dm, h24, dse});
  endtask

  task automatic set_time(int s, int m, int h, int w, int d, int o, int y, int c);
    ms = s; mm = m; mh = h; mw = w; md = d; mo = o; my = y; mc = c; mfd = 0;
    wr(8'h00, 8'(enc(s))); wr(8'h02, 8'(enc(m))); wr(8'h04, 8'(enc_hr(h)));
    wr(8'h06, 8'(enc(w))); wr(8'h07, 8'(enc(d))); wr(8'h08, 8'(enc(o)));
    wr(8'h09, 8'(enc(y))); wr(8'h7F, 8'(enc(c)));
  endtask

  task automatic tick_once(bit timing);
    int n;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    n = 0;
    while (uip === 1'b1 && n < 64) begin n++; @(negedge clk); end
    if (timing) begin
      chk("R5 uip high cycles", n, LEAD);
      chk("R5 update_done at uip fall", int'(done), 1);
    end
    model_tick();
  endtask

  task automatic check_all(string tag);
    int v;
    rd(8'h00, v); chk({"R7 seconds ", tag}, v, enc(ms));
    rd(8'h02, v); chk({"R7 minutes ", tag}, v, enc(mm));
    rd(8'h04, v); chk({"R4 hours ", tag}, v, enc_hr(mh));
    rd(8'h06, v); chk({"R7 day of week ", tag}, v, enc(mw));
    rd(8'h07, v); chk({"R8 date ", tag}, v, enc(md));
    rd(8'h08, v); chk({"R8 month ", tag}, v, enc(mo));
    rd(8'h09, v); chk({"R3 year ", tag}, v, enc(my));
    rd(8'h7F, v); chk({"R9 century ", tag}, v, enc(mc));
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0; mc = 20;
    mfd = 0; mdm = 0; mh24 = 0; mdse = 0;

    // R1 reset state
    check_all("R1 reset");
    rd(8'h0A, v); chk("R1 control A reset", v, 8'h20);
    rd(8'h0B, v); chk("R1 control B reset", v, 8'h00);

    // R2 unmapped address and read-only UIP bit
    wr(8'h30, 8'h5A);
    rd(8'h30, v); chk("R2 unmapped read", v, 0);
    rd(8'h0C, v); chk("R2 unmapped 0x0C read", v, 0);
    rd(8'h00, v); chk("R2 unmapped write no effect", v, 0);
    wr(8'h0A, 8'hA0);
    rd(8'h0A, v); chk("R2 UIP bit not writable", v, 8'h20);

    // R4 hour layouts
    wr_mode(1, 0, 0, 0); set_time(0, 0, 0, 1, 1, 1, 0, 20);
    rd(8'h04, v); chk("R4 midnight BCD 12h", v, 8'h12);
    wr_mode(1, 1, 0, 0); rd(8'h04, v); chk("R4 midnight bin 12h", v, 8'h0C);
    set_time(0, 0, 12, 1, 1, 1, 0, 20);
    rd(8'h04, v); chk("R4 noon bin 12h", v, 8'h8C);
    wr_mode(1, 0, 0, 0); rd(8'h04, v); chk("R4 noon BCD 12h", v, 8'h92);
    set_time(0, 0, 23, 1, 1, 1, 0, 20);
    wr_mode(1, 0, 1, 0); rd(8'h04, v); chk("R3 R4 23h BCD 24h", v, 8'h23);

    // R6 hold bit and divider block ticks
    set_time(10, 0, 5, 2, 3, 4, 5, 20);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R6 no uip while held", int'(uip), 0);
    repeat (LEAD + 2) @(negedge clk);
    rd(8'h00, v); chk("R6 held time unchanged", v, 8'h10);
    wr_mode(0, 0, 1, 0);
    wr(8'h0A, 8'h00);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R6 no uip divider off", int'(uip), 0);
    repeat (LEAD + 2) @(negedge clk);
    rd(8'h00, v); chk("R6 divider off time unchanged", v, 8'h10);
    wr(8'h0A, 8'h20);

    // R5 one tick then R6 tick during pending update
    tick_once(1);
    rd(8'h00, v); chk("R5 advanced one second", v, 8'h11);
    @(negedge clk); tick = 1'b1; @(negedge clk); @(negedge clk); tick = 1'b0;
    while (uip === 1'b1) @(negedge clk);
    model_tick();
    rd(8'h00, v); chk("R6 second tick while pending ignored", v, 8'h12);

    // R8 leap and non-leap February, R9 century carry
    wr_mode(1, 0, 1, 0); set_time(59, 59, 23, 3, 28, 2, 24, 20); wr_mode(0, 0, 1, 0);
    tick_once(1); check_all("R8 leap Feb 28");
    rd(8'h07, v); chk("R8 leap day 29", v, 8'h29);
    wr_mode(1, 0, 1, 0); set_time(59, 59, 23, 3, 28, 2, 23, 20); wr_mode(0, 0, 1, 0);
    tick_once(1); check_all("R8 non-leap Feb 28");
    wr_mode(1, 1, 1, 0); set_time(59, 59, 23, 7, 31, 12, 99, 19); wr_mode(0, 1, 1, 0);
    tick_once(1); check_all("R9 year 99 rollover");
    rd(8'h7F, v); chk("R9 century 20 binary", v, 20);

    // R10 daylight saving
    wr_mode(1, 0, 1, 1); set_time(59, 59, 1, 1, 2, 4, 23, 20); wr_mode(0, 0, 1, 1);
    tick_once(1); rd(8'h04, v); chk("R10 spring forward", v, 8'h03);
    wr_mode(1, 0, 1, 0); set_time(59, 59, 1, 1, 2, 4, 23, 20); wr_mode(0, 0, 1, 0);
    tick_once(1); rd(8'h04, v); chk("R10 DSE off no jump", v, 8'h02);
    wr_mode(1, 0, 1, 1); set_time(59, 59, 1, 1, 29, 10, 23, 20); wr_mode(0, 0, 1, 1);
    tick_once(1); rd(8'h04, v); chk("R10 fall back", v, 8'h01);
    for (int i = 0; i < 3600; i++) tick_once(0);
    check_all("R10 fall back only once");
    rd(8'h04, v); chk("R10 hour two after repeated hour", v, 8'h02);

    // random mix of times and modes
    for (int it = 0; it < 150; it++) begin
      int s, m, h, w, d, o, y, c, nt;
      bit dm, h24, dse;
      dm = 1'($urandom_range(1, 0)); h24 = 1'($urandom_range(1, 0));
      dse = 1'($urandom_range(1, 0));
      o = $urandom_range(12, 1); y = $urandom_range(99, 0); c = $urandom_range(20, 19);
      d = ($urandom_range(1, 0) == 1) ? dim(o, y) : $urandom_range(dim(o, y), 1);
      s = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
      m = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
      case ($urandom_range(2, 0))
        0: h = 23;
        1: h = 1;
        default: h = $urandom_range(23, 0);
      endcase
      w = $urandom_range(7, 1);
      wr_mode(1, dm, h24, dse);
      set_time(s, m, h, w, d, o, y, c);
      wr_mode(0, dm, h24, dse);
      nt = $urandom_range(3, 1);
      for (int k = 0; k < nt; k++) tick_once(1);
      if ($urandom_range(1, 0) == 1)
        wr_mode(0, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), dse);
      check_all("R3 random");
    end

    summary();
  end
endmodule